// File: doc/BRIEF.md
# Prescaled Down-Counting Timer with Watchdog

This block is a single timing channel. A clock prescaler with a one-based divisor feeds a period counter. Software programs three registers: a mode word, a packed configuration word that holds the divisor and the period, and a flag word. The channel can fire once and stop, fire every period, or act as a watchdog. Each expiry sets a flag. The flag can drive an interrupt line. In watchdog mode an expiry instead produces a one-clock reset pulse.

Software services the watchdog by writing the single byte 0xA5 into the top byte of the mode word. That write reloads the count and leaves every mode setting as it was. One counter serves both uses, so a single channel is either a timer or a watchdog at any one time.

Top module: `pscl_timer`

## Requirements
- R1: After reset the mode, configuration and flag words all read 0, and both `irq_o` and `wdog_rst_o` are low.
- R2: The configuration word is at address 1. Its bits 31:16 hold the divisor and bits 15:0 hold the period, and each byte is written only when its byte enable is set. Any write to this address restarts the prescaler and reloads the period counter at the same edge.
- R3: The divisor is one-based. A value of D from 1 to 65535 divides by D, and 0 divides by 65536. An expiry occurs P×D clocks after the edge that starts the count. A period of 0 behaves as 1.
- R4: The mode word is at address 0. Bit 12 is the run bit, and the count advances only while it is 1. Clearing it stops the count. When bit 10 is 0, an expiry clears the run bit.
- R5: When bit 10 of the mode word is 1 and the channel is not in watchdog mode, the counter reloads at each expiry and fires again every P×D clocks.
- R6: Each expiry sets bit 0 of the flag word at address 2, and that bit reads back as 1. A write to the flag word with byte enable 0 set clears each flag whose data bit is 1. If a clear and an expiry fall on the same edge, the expiry wins.
- R7: `irq_o` is high exactly while a flag is set and mode bit 8 (interrupt enable) is 1.
- R8: Mode bit 15 selects watchdog mode. While it is 1, mode bit 8 is held at 0 and reads back as 0.
- R9: A write to address 0 with byte enables 4'b1000 and data bits 31:24 equal to 0xA5 restarts the count and changes no mode bit. A byte-3-only write with any other value has no effect.
- R10: A watchdog expiry drives `wdog_rst_o` high for exactly one clock, on the same edge that sets the flag, and clears the run bit.
- R11: A restart by the service byte on the same edge as an expiry wins: that expiry is dropped and a full period begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 mode, 1 configuration, 2 flags |
| reg_wdata_i | input | 32 | Write data |
| reg_be_i | input | 4 | Byte enables for the write |
| reg_rdata_o | output | 32 | Read data of the selected register (combinational) |
| irq_o | output | 1 | Interrupt request |
| wdog_rst_o | output | 1 | Watchdog reset pulse |

## Verification
A register write takes effect at the clock edge that captures it, and read data follows the address in the same cycle. An expiry becomes visible on the flag, `irq_o` and `wdog_rst_o` exactly P×D edges after the edge that started or last restarted the count. The bench records the cycle number of each capturing edge. From that number it books every expected value on a cycle-ordered scoreboard, including a low value one cycle before each expiry and, for the reset pulse, one cycle after. A monitor compares at the falling edge of the due cycle, so a result that comes early or late fails in the same way as a wrong value.

// File: rtl/pscl_timer_pkg.sv
package pscl_timer_pkg;
    localparam int REG_W  = 32;
    localparam int BE_W   = REG_W / 8;
    localparam int FLAG_W = 4;
    localparam logic [7:0] KICK_BYTE = 8'hA5;

    // mode word bit positions (software visible)
    localparam int BIT_IRQEN = 8;
    localparam int BIT_CONT  = 10;
    localparam int BIT_RUN   = 12;
    localparam int BIT_WDOG  = 15;

    typedef enum logic [1:0] {
        ADDR_MODE   = 2'd0,
        ADDR_CFG    = 2'd1,
        ADDR_FLAGS  = 2'd2
    } reg_addr_e;

    typedef struct packed {
        logic wdog;
        logic run;
        logic cont;
        logic irqen;
    } mode_t;
endpackage

// File: rtl/pscl_timer_prescaler.sv
module pscl_timer_prescaler #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         run_i,
    input  logic         restart_i,
    input  logic [W-1:0] div_i,
    output logic         tick_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_q, st_d;
    logic [W-1:0] last;

    // div-1 wraps to all ones when div is 0: terminal count 2^W-1, divide by 2^W
    assign last   = div_i - {{(W-1){1'b0}}, 1'b1};
    assign tick_o = run_i && !restart_i && (st_q.cnt == last);

    always_comb begin
        st_d = st_q;
        if (!run_i || restart_i || tick_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + {{(W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pscl_timer_period.sv
module pscl_timer_period #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         run_i,
    input  logic         restart_i,
    input  logic         tick_i,
    input  logic [W-1:0] load_i,
    output logic         expire_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] cnt;
    } per_st_t;

    per_st_t st_q, st_d;

    // a period of 0 expires on the first tick, like a period of 1
    assign expire_o = tick_i && (st_q.cnt <= ONE);

    always_comb begin
        st_d = st_q;
        if (!run_i || restart_i) begin
            st_d.cnt = load_i;
        end else if (tick_i) begin
            st_d.cnt = expire_o ? load_i : (st_q.cnt - ONE);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pscl_timer_ctrl.sv
module pscl_timer_ctrl
    import pscl_timer_pkg::*;
#(
    parameter int PRE_W = 16,
    parameter int PER_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [1:0]       addr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic [BE_W-1:0]  be_i,
    input  logic             expire_i,
    output logic [REG_W-1:0] rdata_o,
    output logic             run_o,
    output logic             restart_o,
    output logic [PRE_W-1:0] div_o,
    output logic [PER_W-1:0] load_o,
    output logic             irq_o,
    output logic             wdog_rst_o
);
    localparam int CFG_W = PRE_W + PER_W;
    localparam logic [BE_W-1:0] KICK_BE = {1'b1, {(BE_W-1){1'b0}}};

    typedef struct packed {
        mode_t             mode;
        logic [CFG_W-1:0]  cfg;
        logic [FLAG_W-1:0] flags;
        logic              wrst;
    } ctrl_st_t;

    ctrl_st_t st_q, st_d;
    logic wr_mode, wr_cfg, wr_flags, kick;
    logic [FLAG_W-1:0] clr;

    assign wr_mode  = wr_i && (addr_i == ADDR_MODE);
    assign wr_cfg   = wr_i && (addr_i == ADDR_CFG);
    assign wr_flags = wr_i && (addr_i == ADDR_FLAGS);
    assign kick     = wr_mode && (be_i == KICK_BE) &&
                      (wdata_i[REG_W-1 -: 8] == KICK_BYTE);
    assign clr      = (wr_flags && be_i[0]) ? wdata_i[FLAG_W-1:0] : '0;

    always_comb begin
        st_d = st_q;
        // expiry side effects first, so a same-edge software write wins
        if (expire_i && (st_q.mode.wdog || !st_q.mode.cont)) begin
            st_d.mode.run = 1'b0;
        end
        if (wr_mode && be_i[BIT_RUN/8]) begin
            st_d.mode.wdog  = wdata_i[BIT_WDOG];
            st_d.mode.run   = wdata_i[BIT_RUN];
            st_d.mode.cont  = wdata_i[BIT_CONT];
            st_d.mode.irqen = wdata_i[BIT_IRQEN];
        end
        if (st_d.mode.wdog) begin
            st_d.mode.irqen = 1'b0;
        end
        if (wr_cfg) begin
            for (int i = 0; i < CFG_W; i++) begin
                if (be_i[i/8]) begin
                    st_d.cfg[i] = wdata_i[i];
                end
            end
        end
        st_d.flags = (st_q.flags & ~clr) | {{(FLAG_W-1){1'b0}}, expire_i};
        st_d.wrst  = expire_i && st_q.mode.wdog;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_MODE: begin
                rdata_o[BIT_WDOG]  = st_q.mode.wdog;
                rdata_o[BIT_RUN]   = st_q.mode.run;
                rdata_o[BIT_CONT]  = st_q.mode.cont;
                rdata_o[BIT_IRQEN] = st_q.mode.irqen;
            end
            ADDR_CFG:   rdata_o = REG_W'(st_q.cfg);
            ADDR_FLAGS: rdata_o = REG_W'(st_q.flags);
            default:    rdata_o = '0;
        endcase
    end

    assign run_o      = st_q.mode.run;
    assign restart_o  = kick || wr_cfg;
    assign div_o      = st_q.cfg[CFG_W-1:PER_W];
    // next-state period, so a configuration write reloads with the new value
    assign load_o     = st_d.cfg[PER_W-1:0];
    assign irq_o      = st_q.mode.irqen && (|st_q.flags);
    assign wdog_rst_o = st_q.wrst;
endmodule

// File: rtl/pscl_timer.sv
module pscl_timer
    import pscl_timer_pkg::*;
#(
    parameter int PRE_W = 16,
    parameter int PER_W = 16
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        reg_wr_i,
    input  logic [1:0]  reg_addr_i,
    input  logic [31:0] reg_wdata_i,
    input  logic [3:0]  reg_be_i,
    output logic [31:0] reg_rdata_o,
    output logic        irq_o,
    output logic        wdog_rst_o
);
    logic             run;
    logic             restart;
    logic             pre_tick;
    logic             expire;
    logic [PRE_W-1:0] div;
    logic [PER_W-1:0] load;

    pscl_timer_ctrl #(.PRE_W(PRE_W), .PER_W(PER_W)) u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (reg_wr_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .be_i       (reg_be_i),
        .expire_i   (expire),
        .rdata_o    (reg_rdata_o),
        .run_o      (run),
        .restart_o  (restart),
        .div_o      (div),
        .load_o     (load),
        .irq_o      (irq_o),
        .wdog_rst_o (wdog_rst_o)
    );

    pscl_timer_prescaler #(.W(PRE_W)) u_pre (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run),
        .restart_i (restart),
        .div_i     (div),
        .tick_o    (pre_tick)
    );

    pscl_timer_period #(.W(PER_W)) u_per (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run),
        .restart_i (restart),
        .tick_i    (pre_tick),
        .load_i    (load),
        .expire_o  (expire)
    );
endmodule

// File: rtl/pscl_timer_chk.sv
module pscl_timer_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic tick_i,
    input logic run_i,
    input logic expire_i,
    input logic restart_i,
    input logic reg_wr_i,
    input logic irq_i,
    input logic wdog_rst_i
);
    // R4: the prescaler only ticks while the run bit is set
    assert_tick_needs_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |-> run_i);

    // R10: reset pulse lasts exactly one clock
    assert_rst_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdog_rst_i |=> !wdog_rst_i);

    // R10: a reset pulse always follows an expiry
    assert_rst_after_expiry_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdog_rst_i |-> $past(expire_i));

    // R10: the channel has stopped when the pulse is out, unless software wrote
    assert_rst_stops_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wdog_rst_i && !$past(reg_wr_i)) |-> !run_i);

    // R11: a restart suppresses any expiry on the same edge
    assert_restart_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |-> !expire_i);

    // R7: interrupt only rises after an expiry or a register write
    assert_irq_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_i) |-> ($past(expire_i) || $past(reg_wr_i)));
endmodule

bind pscl_timer pscl_timer_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (pre_tick),
    .run_i      (run),
    .expire_i   (expire),
    .restart_i  (restart),
    .reg_wr_i   (reg_wr_i),
    .irq_i      (irq_o),
    .wdog_rst_i (wdog_rst_o)
);

// File: tb/pscl_timer_tb_top.sv
module pscl_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT_CYC  = 150000;
    localparam int SEL_IRQ = 0, SEL_WRST = 1, SEL_RD = 2;
    localparam logic [1:0] A_MODE = 2'd0, A_CFG = 2'd1, A_FLAGS = 2'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  be = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        wrst;

    pscl_timer dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_be_i    (be),
        .reg_rdata_o (rdata),
        .irq_o       (irq),
        .wdog_rst_o  (wrst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          due;
        int          sel;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];
    int n_run = 0;
    int n_fail = 0;

    task automatic expect_at(input int due, input int sel, input logic [31:0] exp, input string tag);
        item_t it;
        int idx;
        it.due = due; it.sel = sel; it.exp = exp; it.tag = tag;
        idx = sbq.size();
        for (int i = 0; i < sbq.size(); i++) begin
            if (sbq[i].due > due) begin
                idx = i;
                break;
            end
        end
        sbq.insert(idx, it);
    endtask

    // monitor: compares every booked item in its due cycle
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            item_t it;
            logic [31:0] obs;
            it = sbq.pop_front();
            case (it.sel)
                SEL_IRQ:  obs = {31'b0, irq};
                SEL_WRST: obs = {31'b0, wrst};
                default:  obs = rdata;
            endcase
            n_run++;
            if (it.due != cyc || obs !== it.exp) begin
                n_fail++;
                $display("FAIL %s: cycle %0d (due %0d) actual %h expected %h",
                         it.tag, cyc, it.due, obs, it.exp);
            end
        end
    end

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d, input logic [3:0] b,
                             output int edge_c);
        wr = 1'b1; addr = a; wdata = d; be = b;
        @(posedge clk); #1;
        wr = 1'b0; be = '0;
        edge_c = cyc;
    endtask

    task automatic reg_read_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        expect_at(cyc, SEL_RD, exp, tag);
        @(posedge clk); #1;
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * LIMIT_CYC);
        n_fail++;
        $display("FAIL watchdog: run hung, actual cycle %0d expected completion", cyc);
        finish_run();
    end

    initial begin
        int t, t2, k, s, x;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        expect_at(cyc, SEL_IRQ, 0, "R1 irq low");
        expect_at(cyc, SEL_WRST, 0, "R1 wdog reset low");
        reg_read_chk(A_MODE, 32'h0, "R1 mode");
        reg_read_chk(A_CFG, 32'h0, "R1 config");
        reg_read_chk(A_FLAGS, 32'h0, "R1 flags");

        // R3/R4 one-shot, divisor 1, period 3
        reg_write(A_CFG, 32'h0001_0003, 4'hF, t);
        reg_write(A_MODE, 32'h0000_1100, 4'hF, t);
        expect_at(t + 2, SEL_IRQ, 0, "R3 not yet");
        expect_at(t + 3, SEL_IRQ, 1, "R3 expiry P*D");
        wait_to(t + 4);
        reg_read_chk(A_MODE, 32'h0000_0100, "R4 one-shot clears run");
        reg_read_chk(A_FLAGS, 32'h1, "R6 flag set");
        reg_write(A_FLAGS, 32'hF, 4'h1, t);
        expect_at(t, SEL_IRQ, 0, "R6 write-one clear");
        wait_to(t + 6);
        reg_read_chk(A_FLAGS, 32'h0, "R4 no refire after one-shot");

        // R3 divisor 0 means 65536
        reg_write(A_CFG, 32'h0000_0001, 4'hF, t);
        reg_write(A_MODE, 32'h0000_1100, 4'hF, t);
        expect_at(t + 65535, SEL_IRQ, 0, "R3 zero divisor early");
        expect_at(t + 65536, SEL_IRQ, 1, "R3 zero divisor 65536");
        wait_to(t + 65537);
        reg_write(A_FLAGS, 32'h1, 4'h1, x);

        // R5 continuous, divisor 3, period 2
        reg_write(A_CFG, 32'h0003_0002, 4'hF, t);
        reg_write(A_MODE, 32'h0000_1500, 4'hF, t);
        expect_at(t + 5, SEL_IRQ, 0, "R5 first not yet");
        expect_at(t + 6, SEL_IRQ, 1, "R5 first expiry");
        wait_to(t + 7);
        reg_write(A_FLAGS, 32'h1, 4'h1, x);
        expect_at(x, SEL_IRQ, 0, "R6 cleared between periods");
        expect_at(t + 11, SEL_IRQ, 0, "R5 second not yet");
        expect_at(t + 12, SEL_IRQ, 1, "R5 second expiry");
        wait_to(t + 13);
        reg_write(A_MODE, 32'h0000_0500, 4'hF, x);
        reg_write(A_FLAGS, 32'h1, 4'h1, x);
        wait_to(x + 12);
        reg_read_chk(A_FLAGS, 32'h0, "R4 cleared run stops count");

        // R7 interrupt gating
        reg_write(A_CFG, 32'h0001_0002, 4'hF, t);
        reg_write(A_MODE, 32'h0000_1000, 4'hF, t);
        expect_at(t + 2, SEL_IRQ, 0, "R7 masked");
        wait_to(t + 3);
        reg_read_chk(A_FLAGS, 32'h1, "R7 flag while masked");
        reg_write(A_MODE, 32'h0000_0100, 4'hF, t2);
        expect_at(t2, SEL_IRQ, 1, "R7 unmasked");
        reg_write(A_FLAGS, 32'h1, 4'h1, x);

        // R2 configuration write restarts, byte enables respected
        reg_write(A_CFG, 32'h0001_0004, 4'hF, t);
        reg_write(A_MODE, 32'h0000_1100, 4'hF, t);
        wait_to(t + 2);
        reg_write(A_CFG, 32'hFFFF_0004, 4'b0011, t2);
        expect_at(t + 4, SEL_IRQ, 0, "R2 old expiry dropped");
        expect_at(t2 + 3, SEL_IRQ, 0, "R2 reload not yet");
        expect_at(t2 + 4, SEL_IRQ, 1, "R2 reload expiry");
        reg_read_chk(A_CFG, 32'h0001_0004, "R2 byte enables");
        wait_to(t2 + 5);
        reg_write(A_FLAGS, 32'h1, 4'h1, x);

        // R8/R9/R10 watchdog with service
        reg_write(A_CFG, 32'h0001_0005, 4'hF, t);
        reg_write(A_MODE, 32'h0000_9100, 4'hF, t);
        expect_at(t + 5, SEL_WRST, 0, "R9 service held off expiry");
        reg_read_chk(A_MODE, 32'h0000_9000, "R8 irq enable held clear");
        reg_write(A_MODE, 32'hA500_0000, 4'b1000, k);
        wait_to(k + 2);
        reg_write(A_MODE, 32'hA500_0000, 4'b1000, k);
        wait_to(k + 2);
        reg_write(A_MODE, 32'hA500_0000, 4'b1000, k);
        expect_at(k + 4, SEL_WRST, 0, "R10 not yet");
        expect_at(k + 5, SEL_WRST, 1, "R10 reset pulse");
        expect_at(k + 5, SEL_IRQ, 0, "R8 no irq in watchdog");
        expect_at(k + 6, SEL_WRST, 0, "R10 one clock only");
        reg_read_chk(A_MODE, 32'h0000_9000, "R9 service keeps mode");
        wait_to(k + 6);
        reg_read_chk(A_MODE, 32'h0000_8000, "R10 run cleared");
        reg_read_chk(A_FLAGS, 32'h1, "R6 watchdog flag");
        reg_write(A_FLAGS, 32'h1, 4'h1, x);

        // R9 wrong byte ignored
        reg_write(A_MODE, 32'h0000_9000, 4'hF, s);
        reg_write(A_MODE, 32'h5A00_0000, 4'b1000, x);
        expect_at(s + 4, SEL_WRST, 0, "R9 wrong byte not yet");
        expect_at(s + 5, SEL_WRST, 1, "R9 wrong byte ignored");
        wait_to(s + 6);
        reg_read_chk(A_MODE, 32'h0000_8000, "R9 wrong byte no mode change");

        // R11 service on the expiry edge
        reg_write(A_MODE, 32'h0000_9000, 4'hF, s);
        wait_to(s + 4);
        reg_write(A_MODE, 32'hA500_0000, 4'b1000, k);
        expect_at(s + 5, SEL_WRST, 0, "R11 service wins");
        expect_at(k + 4, SEL_WRST, 0, "R11 full period not yet");
        expect_at(k + 5, SEL_WRST, 1, "R11 full period");
        wait_to(k + 8);

        if (sbq.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: actual %0d items left expected 0", sbq.size());
        end
        finish_run();
    end
endmodule